// File: doc/BRIEF.md
# Recombinable Timer/Counter with Capture

This block is a timer/counter built from two 8-bit count halves and one 8-bit programmable prescaler. A 2-bit mode field joins these parts in one of four ways. In the first, both halves are prescaled timers. In the second, one half is a prescaled timer and the other counts external events. In the third, the halves form one 16-bit prescaled timer. In the fourth, they form one 16-bit event counter. Every count has a capture register of the same width. A synchronized rising edge on the capture trigger copies the live count into it. The prescaler tick is also driven out, so neighbouring logic can use it as a clock enable.

Software sets up the block through a small write port. The address map is: 0 mode, 1 prescaler reload, 2 low match byte, 3 high match byte, 4 flag clear. When a count equals its match value on a tick, it returns to zero on that tick and raises a sticky interrupt flag.

A two-state controller sequences the counting. Reset or a mode write enters `ST_CLEAR`, where all counts and the prescaler are held at zero. On the next clock it always moves to `ST_RUN` (transition *release*). From `ST_RUN`, a mode write returns it to `ST_CLEAR` (transition *reconfigure*). Otherwise it stays in `ST_RUN` (transition *hold*).

Top module: `tmc_timer`

## Requirements
- R1: After reset, `count_o`, `capture_o`, `irq_lo_o` and `irq_hi_o` are all zero.
- R2: In mode 0, each half advances once per prescaler tick. A tick occurs every reload+1 clocks. The low half wraps at match byte 2 and the high half wraps at match byte 3, each on its own. After the mode write at edge W, the count after edge W+k reflects floor((k-1)/(reload+1)) ticks.
- R3: In mode 1, the low half (`count_o[7:0]`) counts prescaler ticks and the high half (`count_o[15:8]`) counts rising edges of `evt_in`.
- R4: In mode 2, the two halves form one 16-bit timer. The low half carries into the high half. The timer wraps to zero on the tick where it equals {match byte 3, match byte 2}.
- R5: In mode 3, `count_o` is a 16-bit counter that advances by exactly one per rising edge of `evt_in`, however long the input stays high. It ignores prescaler ticks.
- R6: On a tick where a count equals its match value, that count becomes zero and its flag is set. In the 8-bit modes, the low half sets `irq_lo_o` and the high half sets `irq_hi_o`. In the 16-bit modes only `irq_hi_o` is set. A flag stays set until a write to address 4 with data bit 0 (low) or bit 1 (high) set.
- R7: A rising edge of `cap_trig` passes through a 2-flop synchronizer. On the third clock edge after the rise, the live count is copied into `capture_o`. Otherwise `capture_o` holds its value.
- R8: A write to address 0 (mode in data bits 1:0) clears the counts and the prescaler on that edge. It holds them at zero for one further clock (`ST_CLEAR`).
- R9: While running, `pre_tick_o` is high for one clock in every reload+1 clocks.
- R10: Address 1 loads the prescaler reload, address 2 the low match byte, and address 3 the high match byte. Each write takes effect on the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| cap_trig | input | 1 | Asynchronous capture trigger |
| evt_in | input | 1 | Asynchronous event input |
| count_o | output | 16 | Live count, {high half, low half} |
| capture_o | output | 16 | Captured count, {high half, low half} |
| irq_lo_o | output | 1 | Sticky low-half match flag |
| irq_hi_o | output | 1 | Sticky high-half or 16-bit match flag |
| pre_tick_o | output | 1 | Prescaler tick pulse |

## Verification
The properties are checked on every cycle:
- A mode write zeroes the count on the next cycle.
- Flags stay set until they are cleared.
- The low flag never rises while a 16-bit mode is active.
- The capture register changes only on a synchronized trigger pulse.
- Prescaler ticks are never back to back when the reload is non-zero.
- The 16-bit event count moves by at most one step per cycle.

Only the bench scenarios can show the exact count values. These cover the tick period set by the reload, the wrap points of each half and of the 16-bit counter, the carry between halves, the exact sampling cycle of the capture, and the one-count-per-edge behaviour under long event pulses.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_MLO    = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_MHI    = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 3'd4;

    typedef enum logic [1:0] {
        MD_DUAL_TIMER  = 2'd0,
        MD_TIMER_EVENT = 2'd1,
        MD_WIDE_TIMER  = 2'd2,
        MD_WIDE_EVENT  = 2'd3
    } tmc_mode_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } tmc_state_e;

endpackage

// File: rtl/tmc_edge_sync.sv
module tmc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign rise_o = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/tmc_prescaler.sv
module tmc_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [PRE_W-1:0] reload_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] div_q;

    assign tick_o = run_i && (div_q == reload_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr_i) begin
            div_q <= '0;
        end else if (tick_o) begin
            div_q <= '0;
        end else if (run_i) begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmc_half.sv
module tmc_half #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic              wrap_i,
    input  logic              cap_en_i,
    output logic [HALF_W-1:0] cnt_o,
    output logic [HALF_W-1:0] cap_o
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= wrap_i ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cap_q <= '0;
        else if (cap_en_i) cap_q <= cnt_q;
    end

    assign cnt_o = cnt_q;
    assign cap_o = cap_q;

endmodule

// File: rtl/tmc_timer.sv
module tmc_timer
    import tmc_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic                cap_trig,
    input  logic                evt_in,
    output logic [2*HALF_W-1:0] count_o,
    output logic [2*HALF_W-1:0] capture_o,
    output logic                irq_lo_o,
    output logic                irq_hi_o,
    output logic                pre_tick_o
);
    localparam int FULL_W = 2 * HALF_W;

    // configuration registers
    tmc_mode_e         mode_q;
    logic [PRE_W-1:0]  reload_q;
    logic [HALF_W-1:0] match_lo_q;
    logic [HALF_W-1:0] match_hi_q;

    // controller
    tmc_state_e state_q;
    tmc_state_e state_d;
    logic       mode_wr;
    logic       clear_all;
    logic       run_active;

    // datapath wiring
    logic              pre_tick;
    logic              evt_pulse;
    logic              cap_pulse;
    logic [HALF_W-1:0] cnt_lo, cnt_hi;
    logic [HALF_W-1:0] cap_lo, cap_hi;
    logic              lo_tick, hi_tick;
    logic              lo_eq, hi_eq, full_eq;
    logic              lo_inc, lo_wrap, hi_inc, hi_wrap;
    logic              set_lo, set_hi;
    logic              clr_lo, clr_hi;
    logic              irq_lo_q, irq_hi_q;

    assign mode_wr = wr_en && (wr_addr == ADDR_MODE);
    assign clr_lo  = wr_en && (wr_addr == ADDR_FLAGS) && wr_data[0];
    assign clr_hi  = wr_en && (wr_addr == ADDR_FLAGS) && wr_data[1];

    // register write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MD_DUAL_TIMER;
            reload_q   <= '0;
            match_lo_q <= '1;
            match_hi_q <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_MODE:   mode_q     <= tmc_mode_e'(wr_data[1:0]);
                ADDR_RELOAD: reload_q   <= wr_data[PRE_W-1:0];
                ADDR_MLO:    match_lo_q <= wr_data;
                ADDR_MHI:    match_hi_q <= wr_data;
                default:     ;
            endcase
        end
    end

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // controller: next state (release / hold / reconfigure)
    always_comb begin
        unique case (state_q)
            ST_CLEAR: state_d = mode_wr ? ST_CLEAR : ST_RUN;
            ST_RUN:   state_d = mode_wr ? ST_CLEAR : ST_RUN;
        endcase
    end

    // controller: outputs
    always_comb begin
        unique case (state_q)
            ST_CLEAR: begin
                clear_all  = 1'b1;
                run_active = 1'b0;
            end
            ST_RUN: begin
                clear_all  = mode_wr;
                run_active = 1'b1;
            end
        endcase
    end

    tmc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clear_all),
        .run_i    (run_active),
        .reload_i (reload_q),
        .tick_o   (pre_tick)
    );

    tmc_edge_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (evt_in),
        .rise_o  (evt_pulse)
    );

    tmc_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cap_trig),
        .rise_o  (cap_pulse)
    );

    // tick routing and match detection per mode
    assign lo_eq   = (cnt_lo == match_lo_q);
    assign hi_eq   = (cnt_hi == match_hi_q);
    assign full_eq = lo_eq && hi_eq;

    always_comb begin
        lo_tick = run_active && ((mode_q == MD_WIDE_EVENT) ? evt_pulse : pre_tick);
        hi_tick = run_active && ((mode_q == MD_TIMER_EVENT) ? evt_pulse : pre_tick);
        unique case (mode_q)
            MD_WIDE_TIMER, MD_WIDE_EVENT: begin
                lo_inc  = lo_tick;
                lo_wrap = full_eq;
                hi_inc  = lo_tick && (full_eq || (&cnt_lo));
                hi_wrap = full_eq;
                set_lo  = 1'b0;
                set_hi  = lo_tick && full_eq;
            end
            MD_DUAL_TIMER, MD_TIMER_EVENT: begin
                lo_inc  = lo_tick;
                lo_wrap = lo_eq;
                hi_inc  = hi_tick;
                hi_wrap = hi_eq;
                set_lo  = lo_tick && lo_eq;
                set_hi  = hi_tick && hi_eq;
            end
        endcase
    end

    tmc_half #(.HALF_W(HALF_W)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clear_all),
        .inc_i    (lo_inc),
        .wrap_i   (lo_wrap),
        .cap_en_i (cap_pulse),
        .cnt_o    (cnt_lo),
        .cap_o    (cap_lo)
    );

    tmc_half #(.HALF_W(HALF_W)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clear_all),
        .inc_i    (hi_inc),
        .wrap_i   (hi_wrap),
        .cap_en_i (cap_pulse),
        .cnt_o    (cnt_hi),
        .cap_o    (cap_hi)
    );

    // sticky flags: a new match wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_lo_q <= 1'b0;
            irq_hi_q <= 1'b0;
        end else begin
            irq_lo_q <= set_lo || (irq_lo_q && !clr_lo);
            irq_hi_q <= set_hi || (irq_hi_q && !clr_hi);
        end
    end

    assign count_o    = {cnt_hi, cnt_lo};
    assign capture_o  = {cap_hi, cap_lo};
    assign irq_lo_o   = irq_lo_q;
    assign irq_hi_o   = irq_hi_q;
    assign pre_tick_o = pre_tick;

endmodule

// File: rtl/tmc_timer_chk.sv
module tmc_timer_chk #(
    parameter int HALF_W = 8,
    parameter int PRE_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          wr_addr,
    input logic [HALF_W-1:0]   wr_data,
    input logic [2*HALF_W-1:0] count_o,
    input logic [2*HALF_W-1:0] capture_o,
    input logic                irq_lo_o,
    input logic                irq_hi_o,
    input logic                pre_tick_o,
    input logic [1:0]          mode_q,
    input logic [PRE_W-1:0]    reload_q,
    input logic                cap_pulse,
    input logic                run_active
);
    localparam int FULL_W = 2 * HALF_W;

    p_mode_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> (count_o == '0));

    p_lo_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo_o && !(wr_en && wr_addr == 3'd4 && wr_data[0])) |=> irq_lo_o);

    p_hi_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi_o && !(wr_en && wr_addr == 3'd4 && wr_data[1])) |=> irq_hi_o);

    p_wide_no_lo_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && !(wr_en && wr_addr == 3'd0)) |=> !$rose(irq_lo_o));

    p_capture_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(capture_o));

    p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick_o && reload_q != '0 && !wr_en) |=> !pre_tick_o);

    p_event_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd3 && run_active && !wr_en) |=>
            (count_o == $past(count_o) ||
             count_o == FULL_W'($past(count_o) + 1'b1) ||
             count_o == '0));

endmodule

bind tmc_timer tmc_timer_chk #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .count_o    (count_o),
    .capture_o  (capture_o),
    .irq_lo_o   (irq_lo_o),
    .irq_hi_o   (irq_hi_o),
    .pre_tick_o (pre_tick_o),
    .mode_q     (mode_q),
    .reload_q   (reload_q),
    .cap_pulse  (cap_pulse),
    .run_active (run_active)
);

// File: tb/tb_tmc_timer.sv
module tb_tmc_timer;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 6;

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  rel;
        logic [15:0] match;
        logic [15:0] k;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    // k: edges after the mode write; exp from floor((k-1)/(rel+1)) ticks
    localparam vec_t VECS [N_VEC] = '{
        '{2'd0, 8'd0, 16'h0904, 16'd13,  16'h0202, 4'd2},
        '{2'd0, 8'd2, 16'hFF02, 16'd31,  16'h0A01, 4'd2},
        '{2'd2, 8'd0, 16'h0105, 16'd300, 16'h0025, 4'd4},
        '{2'd2, 8'd0, 16'hFFFF, 16'd260, 16'h0103, 4'd4},
        '{2'd2, 8'd3, 16'h0010, 16'd50,  16'h000C, 4'd4},
        '{2'd0, 8'd1, 16'h0300, 16'd11,  16'h0100, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cap_trig = 1'b0;
    logic        evt_in = 1'b0;
    logic [15:0] count_o, capture_o;
    logic        irq_lo_o, irq_hi_o, pre_tick_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmc_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cap_trig   (cap_trig),
        .evt_in     (evt_in),
        .count_o    (count_o),
        .capture_o  (capture_o),
        .irq_lo_o   (irq_lo_o),
        .irq_hi_o   (irq_hi_o),
        .pre_tick_o (pre_tick_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // returns just after edge W+1 (mode write at edge W)
    task automatic setup(input logic [1:0] m, input logic [7:0] r, input logic [15:0] mt);
        wr(3'd1, r);
        wr(3'd2, mt[7:0]);
        wr(3'd3, mt[15:8]);
        wr(3'd0, {6'd0, m});
        wr(3'd4, 8'h03);
    endtask

    task automatic pulse_evt(input int n, input int hold);
        for (int i = 0; i < n; i++) begin
            evt_in = 1'b1;
            repeat (hold) @(negedge clk);
            evt_in = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ticks;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 count", count_o, 0);
        check("R1 capture", capture_o, 0);
        check("R1 flags", {irq_hi_o, irq_lo_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R2, R4, R10
        for (int v = 0; v < N_VEC; v++) begin
            setup(VECS[v].mode, VECS[v].rel, VECS[v].match);
            repeat (int'(VECS[v].k) - 1) @(negedge clk);
            check($sformatf("R%0d R10 vec%0d", VECS[v].req, v), count_o, VECS[v].exp);
        end

        // R6: low flag in mode 0, match 3, reload 0
        setup(2'd0, 8'd0, 16'hC803);
        repeat (3) @(negedge clk);
        check("R6 no flag before match", {irq_hi_o, irq_lo_o}, 2'b00);
        check("R2 lo at match", count_o[7:0], 8'd3);
        @(negedge clk);
        check("R6 lo flag set", {irq_hi_o, irq_lo_o}, 2'b01);
        check("R6 lo wrapped", count_o[7:0], 8'd0);
        @(negedge clk);
        check("R6 lo flag sticky", irq_lo_o, 1'b1);
        wr(3'd4, 8'h01);
        check("R6 lo flag cleared", irq_lo_o, 1'b0);

        // R6: 16-bit mode raises only the high flag
        setup(2'd2, 8'd0, 16'h0005);
        repeat (9) @(negedge clk);
        check("R6 wide flags", {irq_hi_o, irq_lo_o}, 2'b10);
        check("R4 wide wrap count", count_o, 16'd3);

        // R3: mode 1, high half counts events
        setup(2'd1, 8'd0, 16'hFF32);
        pulse_evt(3, 2);
        check("R3 event half", count_o[15:8], 8'd3);
        ticks = int'(count_o[7:0]);
        @(negedge clk);
        check("R3 timer half advances", count_o[7:0], 8'((ticks + 1) % 51));

        // R5: mode 3, long holds count once
        setup(2'd3, 8'd0, 16'hFFFF);
        pulse_evt(2, 2);
        pulse_evt(1, 12);
        pulse_evt(2, 3);
        check("R5 one per edge", count_o, 16'd5);
        repeat (6) @(negedge clk);
        check("R5 ignores prescaler", count_o, 16'd5);

        // R5/R6: mode 3 wraps at match 2
        setup(2'd3, 8'd0, 16'h0002);
        pulse_evt(4, 2);
        check("R5 event wrap", count_o, 16'd1);
        check("R6 event flag", {irq_hi_o, irq_lo_o}, 2'b10);

        // R7: capture timing
        setup(2'd2, 8'd0, 16'hFFFF);
        cap_trig = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 captured value", capture_o, 16'd2);
        check("R7 live count", count_o, 16'd3);
        cap_trig = 1'b0;
        repeat (10) @(negedge clk);
        check("R7 capture held", capture_o, 16'd2);

        // R8: mode write mid-run
        wr(3'd0, 8'h02);
        check("R8 cleared on write", count_o, 16'd0);
        @(negedge clk);
        check("R8 held in clear", count_o, 16'd0);
        @(negedge clk);
        check("R8 resumes", count_o, 16'd1);

        // R9: tick density with reload 4
        setup(2'd2, 8'd4, 16'hFFFF);
        ticks = 0;
        for (int c = 0; c < 50; c++) begin
            if (pre_tick_o) ticks++;
            @(negedge clk);
        end
        check("R9 tick count", ticks, 10);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule